// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block collects the event strobes of a bank of timer channels and two outside interrupt sources and places them onto a vector of interrupt lines. The outside sources are the output of an interval-tick generator and the level of a clock-calendar interrupt. Each channel carries a route field that names its destination line, and a trigger type. A level-type event latches a per-channel status bit that keeps the line high until a clear strobe removes it. An edge-type event gives a single-cycle pulse.

A legacy mode redirects the first two channels to two fixed lines, line 0 and line 8, and blocks the two outside sources from reaching those lines. It also drops an enable output that gates the outside interval-tick generator. The clock-calendar level is sampled in every cycle, including while it is blocked, so that line 8 can be put back to that level when legacy mode ends. All outputs are registered. A channel event, a clear strobe or a mode change sampled at one rising edge shows on the outputs from that same edge on.

Top module: `legacy_irq_router`

## Requirements
- R1: With legacy mode off, an active channel drives the line whose index equals its route field. The route field is log2(NUM_LINES) bits wide. Sources that share a line are combined by OR.
- R2: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Every other channel still follows its route field.
- R3: A level-type event (ch_is_level=1) on an enabled channel sets its bit in ch_status and holds its line high. Both stay set until a status_clr strobe for that channel. When an event and a clear arrive in the same cycle, the event wins.
- R4: An edge-type event (ch_is_level=0) raises the channel's line for exactly one cycle and leaves its status bit at 0.
- R5: While a channel's enable is low, or while glb_enable is low, that channel's status bit reads 0, its line contribution is 0, and its events are ignored.
- R6: With legacy mode off, ext_tick_in reaches line 0 one cycle later. In the same mode, ext_clk_in reaches line 8 two cycles later, by way of its capture register. With legacy mode on, neither source reaches any line.
- R7: The ext_clk_in level is captured in every cycle, whatever the mode. In the first update after legacy mode ends, line 0 is low and line 8 equals the captured level.
- R8: In the first update after legacy mode begins, lines 0 and 8 are both low. tick_gate_en is the inverse of legacy_mode, delayed by one cycle.
- R9: While rst is high, all lines and all status bits are 0, tick_gate_en is 1 and the captured clock level is 0. The first update after reset therefore drives line 8 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Legacy redirection mode |
| glb_enable | input | 1 | Global enable for all channels |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_event | input | NUM_CH | Per-channel single-cycle event strobe |
| ch_is_level | input | NUM_CH | Trigger type per channel: 1 level, 0 edge |
| ch_route | input | NUM_CH*log2(NUM_LINES) | Packed route fields; channel i at bits [i*W +: W] |
| status_clr | input | NUM_CH | Write-one-to-clear strobes for status bits |
| ext_tick_in | input | 1 | Outside interval-tick interrupt level |
| ext_clk_in | input | 1 | Outside clock-calendar interrupt level |
| irq_lines | output | NUM_LINES | Registered interrupt lines |
| ch_status | output | NUM_CH | Registered status bits of level events |
| tick_gate_en | output | 1 | Enable for the outside interval-tick generator |

## Verification
The bench builds the router with NUM_CH=4 and NUM_LINES=16. At that size every channel can be swept over all sixteen route values, with both trigger types and in both modes. Sixteen lines still contain the two fixed legacy lines, so the overrides for channels 0 and 1 and the unchanged routing of channels 2 and 3 are checked against every route value. Directed sequences then cover the mode-change updates, the delay of the captured clock level, clears against events in the same cycle, and line sharing.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  // What the legacy-mode input did at the current edge
  typedef enum logic [1:0] {
    MODE_STEADY = 2'd0,
    MODE_ENTER  = 2'd1,
    MODE_EXIT   = 2'd2
  } mode_evt_e;

  // Fixed destinations used while legacy redirection is active
  localparam int TICK_LINE = 0;
  localparam int CLK_LINE  = 8;

endpackage

// File: rtl/lrr_chan_state.sv
module lrr_chan_state #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev,
  input  logic [NUM_CH-1:0] is_level,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              glb_en,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] status_q,
  output logic [NUM_CH-1:0] drive_d
);

  logic [NUM_CH-1:0] status_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic active;
    assign active = ch_en[i] && glb_en;

    always_comb begin
      status_d[i] = status_q[i];
      if (!active)                     status_d[i] = 1'b0;
      else if (ev[i] && is_level[i])   status_d[i] = 1'b1;
      else if (ev[i])                  status_d[i] = 1'b0;
      else if (clr[i])                 status_d[i] = 1'b0;
    end

    // Next-cycle line contribution: latched level or one-cycle edge pulse
    assign drive_d[i] = status_d[i] | (active && ev[i] && !is_level[i]);

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_d[i];
    end

    a_r3_level_sets: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && is_level[i] && active) |=> status_q[i]);
    a_r3_holds_until_clear: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !ev[i] && !clr[i] && active) |=> status_q[i]);
    a_r4_edge_no_status: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && !is_level[i]) |=> !status_q[i]);
    a_r5_off_clears: assert property (@(posedge clk) disable iff (rst)
      (!active) |=> !status_q[i]);
  end

endmodule

// File: rtl/lrr_route_mux.sv
module lrr_route_mux #(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 32,
  parameter int LINE_A    = 0,
  parameter int LINE_B    = 8
) (
  input  logic [NUM_CH-1:0]                      drive_d,
  input  logic [NUM_CH*$clog2(NUM_LINES)-1:0]    route,
  input  logic                                   legacy_mode,
  output logic [NUM_LINES-1:0]                   line_d
);

  localparam int RW = $clog2(NUM_LINES);

  logic [RW-1:0] eff_route [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    if (i == 0) begin : g_fix_a
      assign eff_route[i] = legacy_mode ? RW'(LINE_A) : route[i*RW +: RW];
    end else if (i == 1) begin : g_fix_b
      assign eff_route[i] = legacy_mode ? RW'(LINE_B) : route[i*RW +: RW];
    end else begin : g_free
      assign eff_route[i] = route[i*RW +: RW];
    end
  end

  always_comb begin
    line_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (drive_d[i]) line_d[eff_route[i]] = 1'b1;
    end
  end

endmodule

// File: rtl/lrr_legacy_ctl.sv
module lrr_legacy_ctl
  import lrr_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int LINE_A    = 0,
  parameter int LINE_B    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 legacy_mode,
  input  logic                 ext_tick_in,
  input  logic                 ext_clk_in,
  input  logic [NUM_LINES-1:0] line_d,
  output logic [NUM_LINES-1:0] irq_d,
  output mode_evt_e            mode_evt,
  output logic                 clk_lvl_q,
  output logic                 gate_q
);

  logic legacy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      legacy_q  <= 1'b0;
      clk_lvl_q <= 1'b0;
      gate_q    <= 1'b1;
    end else begin
      legacy_q  <= legacy_mode;
      clk_lvl_q <= ext_clk_in;
      gate_q    <= !legacy_mode;
    end
  end

  always_comb begin
    if (legacy_mode && !legacy_q)      mode_evt = MODE_ENTER;
    else if (!legacy_mode && legacy_q) mode_evt = MODE_EXIT;
    else                               mode_evt = MODE_STEADY;
  end

  always_comb begin
    irq_d = line_d;
    if (!legacy_mode) begin
      irq_d[LINE_A] = line_d[LINE_A] | ext_tick_in;
      irq_d[LINE_B] = line_d[LINE_B] | clk_lvl_q;
    end
    case (mode_evt)
      MODE_ENTER: begin
        irq_d[LINE_A] = 1'b0;
        irq_d[LINE_B] = 1'b0;
      end
      MODE_EXIT: begin
        irq_d[LINE_A] = 1'b0;
        irq_d[LINE_B] = clk_lvl_q;
      end
      default: ;
    endcase
  end

  a_r8_gate_low_in_legacy: assert property (@(posedge clk) disable iff (rst)
    legacy_mode |=> !gate_q);
  a_r8_gate_high_outside: assert property (@(posedge clk) disable iff (rst)
    !legacy_mode |=> gate_q);

endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
  import lrr_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_LINES = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                legacy_mode,
  input  logic                                glb_enable,
  input  logic [NUM_CH-1:0]                   ch_enable,
  input  logic [NUM_CH-1:0]                   ch_event,
  input  logic [NUM_CH-1:0]                   ch_is_level,
  input  logic [NUM_CH*$clog2(NUM_LINES)-1:0] ch_route,
  input  logic [NUM_CH-1:0]                   status_clr,
  input  logic                                ext_tick_in,
  input  logic                                ext_clk_in,
  output logic [NUM_LINES-1:0]                irq_lines,
  output logic [NUM_CH-1:0]                   ch_status,
  output logic                                tick_gate_en
);

  localparam int LINE_A = TICK_LINE;
  localparam int LINE_B = CLK_LINE;

  logic [NUM_CH-1:0]    drive_d;
  logic [NUM_LINES-1:0] line_d;
  logic [NUM_LINES-1:0] irq_d;
  logic [NUM_LINES-1:0] irq_q;
  mode_evt_e            mode_evt;
  logic                 clk_lvl_q;

  lrr_chan_state #(.NUM_CH(NUM_CH)) u_chan (
    .clk      (clk),
    .rst      (rst),
    .ev       (ch_event),
    .is_level (ch_is_level),
    .ch_en    (ch_enable),
    .glb_en   (glb_enable),
    .clr      (status_clr),
    .status_q (ch_status),
    .drive_d  (drive_d)
  );

  lrr_route_mux #(
    .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .LINE_A(LINE_A), .LINE_B(LINE_B)
  ) u_mux (
    .drive_d     (drive_d),
    .route       (ch_route),
    .legacy_mode (legacy_mode),
    .line_d      (line_d)
  );

  lrr_legacy_ctl #(
    .NUM_LINES(NUM_LINES), .LINE_A(LINE_A), .LINE_B(LINE_B)
  ) u_leg (
    .clk         (clk),
    .rst         (rst),
    .legacy_mode (legacy_mode),
    .ext_tick_in (ext_tick_in),
    .ext_clk_in  (ext_clk_in),
    .line_d      (line_d),
    .irq_d       (irq_d),
    .mode_evt    (mode_evt),
    .clk_lvl_q   (clk_lvl_q),
    .gate_q      (tick_gate_en)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  assign irq_lines = irq_q;

  a_r8_enter_lowers: assert property (@(posedge clk) disable iff (rst)
    (mode_evt == MODE_ENTER) |=> (!irq_q[LINE_A] && !irq_q[LINE_B]));
  a_r7_exit_restores: assert property (@(posedge clk) disable iff (rst)
    (mode_evt == MODE_EXIT) |=> (!irq_q[LINE_A] && irq_q[LINE_B] == $past(clk_lvl_q)));
  a_r6_tick_blocked: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && ext_tick_in && !drive_d[0]) |=> !irq_q[LINE_A]);

endmodule

// File: tb/legacy_irq_router_tb.sv
module legacy_irq_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NL  = 16;
  localparam int RW  = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          legacy_mode, glb_enable, ext_tick_in, ext_clk_in;
  logic [NCH-1:0] ch_enable, ch_event, ch_is_level, status_clr;
  logic [NCH*RW-1:0] ch_route;
  logic [NL-1:0] irq_lines;
  logic [NCH-1:0] ch_status;
  logic          tick_gate_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_irq_router #(.NUM_CH(NCH), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .glb_enable(glb_enable),
    .ch_enable(ch_enable), .ch_event(ch_event), .ch_is_level(ch_is_level),
    .ch_route(ch_route), .status_clr(status_clr), .ext_tick_in(ext_tick_in),
    .ext_clk_in(ext_clk_in), .irq_lines(irq_lines), .ch_status(ch_status),
    .tick_gate_en(tick_gate_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input int ch, input logic lvl);
    ch_is_level[ch] = lvl;
    ch_event[ch] = 1'b1;
    @(negedge clk);
    ch_event[ch] = 1'b0;
  endtask

  task automatic clear_st(input int ch);
    status_clr[ch] = 1'b1;
    @(negedge clk);
    status_clr[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; legacy_mode = 1'b0; glb_enable = 1'b0; ext_tick_in = 1'b0;
    ext_clk_in = 1'b1; ch_enable = '0; ch_event = '0; ch_is_level = '0;
    status_clr = '0; ch_route = '0;
    tick(3);
    // R9: reset state
    chk("R9 lines", 32'(irq_lines), 0);
    chk("R9 status", 32'(ch_status), 0);
    chk("R9 gate", 32'(tick_gate_en), 1);
    rst = 1'b0;
    tick(1);
    chk("R9 captured level cleared", 32'(irq_lines[8]), 0);
    tick(1);
    chk("R6 clock to line 8", 32'(irq_lines[8]), 1);
    ext_clk_in = 1'b0;
    tick(3);
    // R6: tick source one cycle
    ext_tick_in = 1'b1;
    tick(1);
    chk("R6 tick to line 0", 32'(irq_lines), 1);
    ext_tick_in = 1'b0;
    tick(1);
    chk("R6 tick released", 32'(irq_lines), 0);

    glb_enable = 1'b1; ch_enable = '1;
    // R1 / R2 sweep over modes, channels, routes, trigger types
    for (int lg = 0; lg < 2; lg++) begin
      legacy_mode = lg[0];
      tick(3);
      for (int ch = 0; ch < NCH; ch++) begin
        for (int r = 0; r < NL; r++) begin
          int eff;
          string tg;
          eff = r;
          if (lg == 1 && ch == 0) eff = 0;
          if (lg == 1 && ch == 1) eff = 8;
          tg = (lg == 1) ? "R2" : "R1";
          ch_route[ch*RW +: RW] = RW'(r);
          pulse_evt(ch, 1'b0);
          chk({tg, " R4 edge line"}, 32'(irq_lines), 32'(1) << eff);
          chk("R4 edge status clear", 32'(ch_status), 0);
          tick(1);
          chk("R4 edge one cycle", 32'(irq_lines), 0);
          pulse_evt(ch, 1'b1);
          chk({tg, " R3 level line"}, 32'(irq_lines), 32'(1) << eff);
          chk("R3 level status", 32'(ch_status), 32'(1) << ch);
          tick(1);
          chk("R3 level held", 32'(irq_lines), 32'(1) << eff);
          clear_st(ch);
          chk("R3 cleared line", 32'(irq_lines), 0);
          chk("R3 cleared status", 32'(ch_status), 0);
        end
        ch_route[ch*RW +: RW] = '0;
      end
    end

    // legacy on: external sources suppressed, level still captured
    ext_clk_in = 1'b1; ext_tick_in = 1'b1;
    tick(3);
    chk("R6 suppressed in legacy", 32'(irq_lines), 0);
    chk("R8 gate low in legacy", 32'(tick_gate_en), 0);
    legacy_mode = 1'b0; ext_clk_in = 1'b0;
    tick(1);
    chk("R7 exit line 8 captured", 32'(irq_lines[8]), 1);
    chk("R7 exit line 0 low", 32'(irq_lines[0]), 0);
    chk("R8 gate restored", 32'(tick_gate_en), 1);
    tick(1);
    chk("R6 tick after exit", 32'(irq_lines), 1);
    ext_tick_in = 1'b0;
    tick(3);

    // R8: entry lowers line 0 even with a channel routed there
    ch_route[2*RW +: RW] = 4'd0;
    pulse_evt(2, 1'b1);
    chk("R1 ch2 on line 0", 32'(irq_lines), 1);
    legacy_mode = 1'b1;
    tick(1);
    chk("R8 entry lowers 0 and 8", 32'(irq_lines), 0);
    tick(1);
    chk("R2 ch2 keeps route", 32'(irq_lines), 1);
    clear_st(2);
    legacy_mode = 1'b0;
    tick(3);

    // R5: disabled channel ignores events; global disable clears status
    ch_enable[3] = 1'b0;
    ch_route[3*RW +: RW] = 4'd5;
    pulse_evt(3, 1'b1);
    chk("R5 disabled line", 32'(irq_lines), 0);
    chk("R5 disabled status", 32'(ch_status), 0);
    ch_enable[3] = 1'b1;
    pulse_evt(3, 1'b1);
    chk("R3 status after enable", 32'(ch_status), 32'h8);
    glb_enable = 1'b0;
    tick(1);
    chk("R5 global off status", 32'(ch_status), 0);
    chk("R5 global off line", 32'(irq_lines), 0);
    glb_enable = 1'b1;
    tick(1);

    // R3: event beats clear in the same cycle
    status_clr[2] = 1'b1;
    pulse_evt(2, 1'b1);
    status_clr[2] = 1'b0;
    chk("R3 event wins over clear", 32'(ch_status), 32'h4);
    clear_st(2);

    // R1: two channels sharing one line combine by OR
    ch_route[2*RW +: RW] = 4'd7;
    ch_route[3*RW +: RW] = 4'd7;
    pulse_evt(2, 1'b1);
    pulse_evt(3, 1'b1);
    chk("R1 shared line", 32'(irq_lines), 32'h80);
    clear_st(2);
    chk("R1 shared line kept", 32'(irq_lines), 32'h80);
    clear_st(3);
    chk("R1 shared line released", 32'(irq_lines), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule